// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply and divide engine of a 32-bit load/store core. It owns two result registers, HI and LO. A multiply leaves the full double-width product split across HI (upper half) and LO (lower half). A divide leaves the remainder in HI and the quotient in LO. Both signed and unsigned forms exist. Direct writes of a source operand into HI or into LO are also provided.

Operations are offered on a valid/ready handshake. Multiplies and ordinary divides run iteratively, one operand bit per cycle, on operand magnitudes, with a sign correction in a final cycle. A divide by zero, or the signed divide of the most negative value by minus one, never traps. It completes in a single cycle with fixed HI/LO values. While an operation is in flight, the unit refuses new operations, and any request to read HI or LO is answered with a stall.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 (signed multiply) treats both operands as two's complement and, when complete, leaves bits 63..32 of the 64-bit product in HI and bits 31..0 in LO.
- R2: Operation code 1 (unsigned multiply) treats both operands as unsigned and splits the 64-bit product into HI (upper) and LO (lower) in the same way.
- R3: Operation code 2 (signed divide) with a non-zero divisor, excluding the overflow case, leaves the quotient rounded toward zero in LO and the remainder in HI, where the remainder carries the sign of the dividend.
- R4: Operation code 3 (unsigned divide) with a non-zero divisor leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R5: Signed divide by zero sets HI to the dividend and LO to 0xFFFFFFFF for a dividend of zero or more, or to 0x00000001 for a negative dividend.
- R6: Signed divide of 0x80000000 by 0xFFFFFFFF (minus one) sets HI to 0 and LO to 0x80000000.
- R7: Unsigned divide by zero sets HI to the dividend and LO to 0xFFFFFFFF.
- R8: Operation code 4 copies op_a into HI and code 5 copies op_a into LO, visible in the cycle after acceptance, leaving the other register unchanged and never raising busy.
- R9: While busy is high, op_ready is low, and an operation presented then is not accepted and has no effect on HI or LO.
- R10: rd_data shows HI when rd_sel is 1 and LO when rd_sel is 0, and rd_stall is high exactly when rd_req is high while busy.
- R11: A multiply, or a divide that is not a special case, holds busy high for exactly W+1 cycles after acceptance. A divide-by-zero or signed-overflow divide holds busy for exactly 1 cycle.
- R12: After reset, HI and LO read 0, busy is low and op_ready is high.
- R13: Operation codes 6 and 7 are accepted and change neither HI, LO nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Unit can take an operation this cycle |
| op_code | input | 3 | Operation code (0..7, see requirements) |
| op_a | input | W | First operand: multiplicand, dividend or move source |
| op_b | input | W | Second operand: multiplier or divisor |
| rd_req | input | 1 | Consumer wants to read HI or LO |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | W | Selected result register |
| rd_stall | output | 1 | Read must wait, a result is pending |
| busy | output | 1 | An iterative operation is in flight |

## Verification
The hardest situation to reach from the ports is an operation that collides with one already in flight. The bench must show that the refused operation leaves no trace, and that a read raised during that window stalls. The bench starts a multiply, waits a few cycles, and then raises op_valid with a divide and rd_req at once. It checks that op_ready is low and rd_stall is high during the window. After completion, HI and LO must hold the multiply product and not the divide result. The one-cycle short path for special divides is checked separately, by counting busy cycles against the iterative length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_DIV_S = 3'd2,
    OP_DIV_U = 3'd3,
    OP_SET_HI = 3'd4,
    OP_SET_LO = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mdu_st_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdu_st_e          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [2*W-1:0]   acc_q, acc_d;
  logic [W-1:0]     mcand_q, mcand_d;
  logic             neg_q, neg_d;

  logic             a_neg, b_neg;
  logic [W-1:0]     a_mag, b_mag;
  logic [W:0]       upper;

  always_comb begin
    a_neg = is_signed & a[W-1];
    b_neg = is_signed & b[W-1];
    a_mag = a_neg ? (~a + 1'b1) : a;
    b_mag = b_neg ? (~b + 1'b1) : b;
    upper = acc_q[0] ? ({1'b0, acc_q[2*W-1:W]} + {1'b0, mcand_q})
                     : {1'b0, acc_q[2*W-1:W]};
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    mcand_d = mcand_q;
    neg_d   = neg_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_RUN;
          cnt_d   = '0;
          acc_d   = {{W{1'b0}}, b_mag};
          mcand_d = a_mag;
          neg_d   = a_neg ^ b_neg;
        end
      end
      ST_RUN: begin
        acc_d = {upper, acc_q[W-1:1]};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_FIX;
      end
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      mcand_q <= '0;
      neg_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      mcand_q <= mcand_d;
      neg_q   <= neg_d;
    end
  end

  assign done = (st_q == ST_FIX);
  assign prod = neg_q ? (~acc_q + 1'b1) : acc_q;

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  mdu_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dv_q, dv_d;
  logic          qneg_q, qneg_d;
  logic          rneg_q, rneg_d;

  logic          a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;
  logic          by_zero, ovf;
  logic [W:0]    r_sh;
  logic          ge;

  always_comb begin
    a_neg   = is_signed & a[W-1];
    b_neg   = is_signed & b[W-1];
    a_mag   = a_neg ? (~a + 1'b1) : a;
    b_mag   = b_neg ? (~b + 1'b1) : b;
    by_zero = (b == '0);
    ovf     = is_signed & (a == MOST_NEG) & (b == ALL_ONES);
    r_sh    = {rem_q, quo_q[W-1]};
    ge      = (r_sh >= {1'b0, dv_q});
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    dv_d   = dv_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d = '0;
          if (by_zero) begin
            st_d   = ST_FIX;
            rem_d  = a;
            quo_d  = a_neg ? ONE : ALL_ONES;
            qneg_d = 1'b0;
            rneg_d = 1'b0;
          end else if (ovf) begin
            st_d   = ST_FIX;
            rem_d  = '0;
            quo_d  = MOST_NEG;
            qneg_d = 1'b0;
            rneg_d = 1'b0;
          end else begin
            st_d   = ST_RUN;
            rem_d  = '0;
            quo_d  = a_mag;
            dv_d   = b_mag;
            qneg_d = a_neg ^ b_neg;
            rneg_d = a_neg;
          end
        end
      end
      ST_RUN: begin
        rem_d = ge ? W'(r_sh - {1'b0, dv_q}) : r_sh[W-1:0];
        quo_d = {quo_q[W-2:0], ge};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) st_d = ST_FIX;
      end
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dv_q   <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dv_q   <= dv_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
    end
  end

  assign done = (st_q == ST_FIX);
  assign quo  = qneg_q ? (~quo_q + 1'b1) : quo_q;
  assign rem  = rneg_q ? (~rem_q + 1'b1) : rem_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_stall,
  output logic         busy
);
  mdu_op_e        op;
  logic           accept;
  logic           mul_start, div_start;
  logic           mul_done, div_done;
  logic [2*W-1:0] mul_prod;
  logic [W-1:0]   div_quo, div_rem;

  logic           busy_q, busy_d;
  logic [W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic           hi_en, lo_en;

  always_comb begin
    op        = mdu_op_e'(op_code);
    accept    = op_valid & ~busy_q;
    mul_start = accept & ((op == OP_MUL_S) | (op == OP_MUL_U));
    div_start = accept & ((op == OP_DIV_S) | (op == OP_DIV_U));
  end

  muldiv_mul #(.W(W)) mul_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mul_start),
    .is_signed (op == OP_MUL_S),
    .a         (op_a),
    .b         (op_b),
    .done      (mul_done),
    .prod      (mul_prod)
  );

  muldiv_div #(.W(W)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .is_signed (op == OP_DIV_S),
    .a         (op_a),
    .b         (op_b),
    .done      (div_done),
    .quo       (div_quo),
    .rem       (div_rem)
  );

  always_comb begin
    busy_d = busy_q;
    if (mul_done | div_done)       busy_d = 1'b0;
    else if (mul_start | div_start) busy_d = 1'b1;

    hi_en = 1'b0;
    lo_en = 1'b0;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (mul_done) begin
      hi_en = 1'b1;
      lo_en = 1'b1;
      hi_d  = mul_prod[2*W-1:W];
      lo_d  = mul_prod[W-1:0];
    end else if (div_done) begin
      hi_en = 1'b1;
      lo_en = 1'b1;
      hi_d  = div_rem;
      lo_d  = div_quo;
    end else if (accept && op == OP_SET_HI) begin
      hi_en = 1'b1;
      hi_d  = op_a;
    end else if (accept && op == OP_SET_LO) begin
      lo_en = 1'b1;
      lo_d  = op_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign busy     = busy_q;
  assign op_ready = ~busy_q;
  assign rd_data  = rd_sel ? hi_q : lo_q;
  assign rd_stall = rd_req & busy_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic [2:0]   op_code,
  input logic [W-1:0] op_a,
  input logic         rd_req,
  input logic         rd_stall,
  input logic         busy,
  input logic         mul_done,
  input logic         div_done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W + 3);
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R11: busy window bounded by the iterative length
  a_r11_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt <= CW'(W)));

  // R11: a multiply or divide taken raises busy next cycle
  a_r11_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code <= 3'd3)) |=> busy);

  // R9: HI and LO frozen while an operation runs
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mul_done && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));

  // R8: move to HI lands the operand
  a_r8_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == 3'd4) |=> (hi_q == $past(op_a) && $stable(lo_q) && !busy));

  // R8: move to LO lands the operand
  a_r8_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code == 3'd5) |=> (lo_q == $past(op_a) && $stable(hi_q) && !busy));

  // R10: a stalled read implies the unit cannot take work
  a_r10_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_req && !op_ready));

  // R11: only one engine finishes at a time
  a_r11_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_done, div_done}));

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .op_a     (op_a),
  .rd_req   (rd_req),
  .rd_stall (rd_stall),
  .busy     (busy),
  .mul_done (mul_done),
  .div_done (div_done),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         op_valid;
  logic         op_ready;
  logic [2:0]   op_code;
  logic [W-1:0] op_a, op_b;
  logic         rd_req, rd_sel;
  logic [W-1:0] rd_data;
  logic         rd_stall;
  logic         busy;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  muldiv_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_data(rd_data), .rd_stall(rd_stall), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one op at a negedge, return busy cycle count seen after acceptance
  task automatic run_op(input logic [2:0] code, input logic [W-1:0] a,
                        input logic [W-1:0] b, output int bcyc);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    bcyc = 0;
    while (busy) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  task automatic read_pair(output logic [W-1:0] hi, output logic [W-1:0] lo);
    rd_sel = 1'b1; #1 hi = rd_data;
    rd_sel = 1'b0; #1 lo = rd_data;
  endtask

  task automatic t_reset;
    logic [W-1:0] hi, lo;
    read_pair(hi, lo);
    chk("R12 hi", 64'(hi), 64'h0);
    chk("R12 lo", 64'(lo), 64'h0);
    chk("R12 busy", 64'(busy), 64'h0);
    chk("R12 ready", 64'(op_ready), 64'h1);
  endtask

  task automatic t_mul(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b, string tag);
    int n;
    logic [W-1:0] hi, lo;
    logic [63:0] exp;
    exp = sgn ? 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}))
              : {32'h0, a} * {32'h0, b};
    run_op(sgn ? 3'd0 : 3'd1, a, b, n);
    read_pair(hi, lo);
    chk({tag, " product"}, {hi, lo}, exp);
    chk("R11 mul busy cycles", 64'(n), 64'(W + 1));
  endtask

  task automatic t_div(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b, string tag);
    int n;
    logic [W-1:0] hi, lo, eq, er;
    if (sgn) begin
      eq = W'($signed(a) / $signed(b));
      er = W'($signed(a) % $signed(b));
    end else begin
      eq = a / b;
      er = a % b;
    end
    run_op(sgn ? 3'd2 : 3'd3, a, b, n);
    read_pair(hi, lo);
    chk({tag, " quotient"}, 64'(lo), 64'(eq));
    chk({tag, " remainder"}, 64'(hi), 64'(er));
    chk("R11 div busy cycles", 64'(n), 64'(W + 1));
  endtask

  task automatic t_special(input logic [2:0] code, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] ehi, input logic [W-1:0] elo, string tag);
    int n;
    logic [W-1:0] hi, lo;
    run_op(code, a, b, n);
    read_pair(hi, lo);
    chk({tag, " hi"}, 64'(hi), 64'(ehi));
    chk({tag, " lo"}, 64'(lo), 64'(elo));
    chk("R11 special busy cycles", 64'(n), 64'd1);
  endtask

  task automatic t_moves;
    int n;
    logic [W-1:0] hi, lo;
    run_op(3'd4, 32'hCAFE_0001, 32'h0, n);
    read_pair(hi, lo);
    chk("R8 set hi", 64'(hi), 64'hCAFE_0001);
    chk("R8 no busy", 64'(n), 64'd0);
    run_op(3'd5, 32'h1234_5678, 32'h0, n);
    read_pair(hi, lo);
    chk("R8 set lo", 64'(lo), 64'h1234_5678);
    chk("R8 hi kept", 64'(hi), 64'hCAFE_0001);
    run_op(3'd6, 32'hDEAD_BEEF, 32'h1, n);
    run_op(3'd7, 32'hDEAD_BEEF, 32'h1, n);
    read_pair(hi, lo);
    chk("R13 hi untouched", 64'(hi), 64'hCAFE_0001);
    chk("R13 lo untouched", 64'(lo), 64'h1234_5678);
    chk("R13 no busy", 64'(n), 64'd0);
  endtask

  task automatic t_collide;
    logic [W-1:0] hi, lo;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; op_a = 32'd1000; op_b = 32'd3000;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    op_valid = 1'b1; op_code = 3'd3; op_a = 32'd77; op_b = 32'd5;
    rd_req = 1'b1;
    #1;
    chk("R9 ready low while busy", 64'(op_ready), 64'h0);
    chk("R10 stall while busy", 64'(rd_stall), 64'h1);
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
    chk("R10 stall released", 64'(rd_stall), 64'h0);
    rd_req = 1'b0;
    read_pair(hi, lo);
    chk("R9 refused op no effect", {hi, lo}, 64'd3000000);
    chk("R10 rd_sel lo", 64'(lo), 64'd3000000);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_a = '0; op_b = '0;
    rd_req = 1'b0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul(1'b1, 32'hFFFF_FFFD, 32'd7, "R1");
    t_mul(1'b1, 32'h8000_0000, 32'h8000_0000, "R1");
    t_mul(1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R1");
    t_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    t_mul(1'b0, 32'h0001_2345, 32'h0000_0000, "R2");
    t_div(1'b1, 32'hFFFF_FFF9, 32'd2, "R3");
    t_div(1'b1, 32'd7, 32'hFFFF_FFFE, "R3");
    t_div(1'b1, 32'h8000_0000, 32'd3, "R3");
    t_div(1'b0, 32'hFFFF_FFFF, 32'd10, "R4");
    t_div(1'b0, 32'd5, 32'h8000_0000, "R4");
    t_special(3'd2, 32'd42, 32'd0, 32'd42, 32'hFFFF_FFFF, "R5 pos");
    t_special(3'd2, 32'hFFFF_FF00, 32'd0, 32'hFFFF_FF00, 32'd1, "R5 neg");
    t_special(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000, "R6");
    t_special(3'd3, 32'h8000_0001, 32'd0, 32'h8000_0001, 32'hFFFF_FFFF, "R7");
    t_moves();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule